// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with IRQ/FIQ Routing

This block collects ten level-sensitive interrupt lines and merges them into two processor request outputs, a normal request (IRQ) and a fast request (FIQ). Each line has its own enable bit, its own choice of output, and, for the two lines fed from external general-purpose pins, a selectable polarity. Software reaches everything through a simple 32-bit register bus with a select strobe and a write flag.

Enables are changed through a pair of write-one-to-act registers, one that sets and one that clears enable bits. With this pair, a driver never has to read, modify and write back a shared mask. Software can also switch in a test word in place of the real inputs, and so raise any combination of lines with no external stimulus. Status registers show the lines that are pending on each output, and software picks which line to service first, taking the highest-numbered set bit. Nothing is latched, so an interrupt stays pending until its source line drops or its enable is cleared.

Top module: `lvl_intc`

## Requirements
- R1: A write to offset 0x08 sets the enable bit of every line whose data bit is 1 and leaves every other enable unchanged. A read of 0x08 returns the current enables in bits 9:0.
- R2: A write to offset 0x0C clears the enable bit of every line whose data bit is 1 and leaves every other enable unchanged. A read of 0x0C returns 0.
- R3: A read of 0x00 returns, in bits 9:0, the conditioned lines that are enabled and whose mode bit is 0.
- R4: The mode register at 0x10 routes each line: bit value 0 sends it to IRQ and 1 sends it to FIQ. A read of 0x20 returns the conditioned lines that are enabled and whose mode bit is 1.
- R5: irq_o is high exactly when the IRQ status is nonzero, and fiq_o is high exactly when the FIQ status is nonzero.
- R6: The level register at 0x14 inverts the polarity of a line when its bit is 1, but only for lines 2 and 4. Level bits for every other line are not stored, read back as 0 and have no effect.
- R7: Bit 0 of the source-select register at 0x18 chooses the inputs: 0 uses the irq_src pins and 1 uses bits 9:0 of the test-source register at 0x1C.
- R8: A read of 0x04 returns the conditioned lines (after source selection and polarity), whatever their enable and mode.
- R9: All lines are level-sensitive. A status bit stays set for as long as its conditioned line is active and enabled, reading it does not clear it, and it clears once the line goes inactive.
- R10: After reset all enables and the mode, level, source-select and test-source registers are 0, and irq_o and fiq_o are low.
- R11: irq_o and fiq_o change on the first rising clock edge after an input pin change. Read data is valid in the cycle that follows the read strobe and holds until the next read.
- R12: Register bits above bit 9 (above bit 0 for source select) read as 0 and ignore writes, and offsets that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_src | input | 10 | Interrupt source lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
On every cycle the assertions check how the enable set and clear writes act on the enable state, that the two status words never share a bit, that no status bit is set for a line that was disabled or routed to the other output, that each output agrees with its status word, and that read data holds between reads. Only the bench scenarios can show that the status values are correct for particular input, polarity, test-source and mode patterns. The same holds for the cycle at which an output answers an input pin, and for the read-back of unused bits and unmapped offsets.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

    localparam int unsigned BUS_AW = 6;
    localparam int unsigned BUS_DW = 32;
    localparam int unsigned IDX_W  = BUS_AW - 2;

    typedef enum logic [IDX_W-1:0] {
        RG_IRQ_STAT = 4'h0,
        RG_RAW      = 4'h1,
        RG_EN_SET   = 4'h2,
        RG_EN_CLR   = 4'h3,
        RG_MODE     = 4'h4,
        RG_LEVEL    = 4'h5,
        RG_SRC_SEL  = 4'h6,
        RG_TEST     = 4'h7,
        RG_FIQ_STAT = 4'h8
    } reg_idx_e;

endpackage

// File: rtl/lvl_intc_regs.sv
module lvl_intc_regs
    import lvl_intc_pkg::*;
#(
    parameter int unsigned NL = 10,
    parameter logic [NL-1:0] LOW_OK = 10'h014
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic [NL-1:0]     irq_stat,
    input  logic [NL-1:0]     fiq_stat,
    input  logic [NL-1:0]     raw_stat,
    output logic [NL-1:0]     en,
    output logic [NL-1:0]     mode,
    output logic [NL-1:0]     level,
    output logic              src_sel,
    output logic [NL-1:0]     test_src,
    output logic [BUS_DW-1:0] rdata
);

    typedef struct packed {
        logic [NL-1:0]     en;
        logic [NL-1:0]     mode;
        logic [NL-1:0]     level;
        logic              src_sel;
        logic [NL-1:0]     test_src;
        logic [BUS_DW-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic [NL-1:0]    wbits;
    logic             unused_bits;

    assign idx         = addr[BUS_AW-1:2];
    assign wbits       = wdata[NL-1:0];
    assign unused_bits = ^{addr[1:0], wdata[BUS_DW-1:NL]};

    function automatic logic [BUS_DW-1:0] widen(input logic [NL-1:0] v);
        logic [BUS_DW-1:0] r;
        r = '0;
        r[NL-1:0] = v;
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (sel && wr) begin
            case (reg_idx_e'(idx))
                RG_EN_SET:  st_d.en       = st_q.en | wbits;
                RG_EN_CLR:  st_d.en       = st_q.en & ~wbits;
                RG_MODE:    st_d.mode     = wbits;
                RG_LEVEL:   st_d.level    = wbits & LOW_OK;
                RG_SRC_SEL: st_d.src_sel  = wdata[0];
                RG_TEST:    st_d.test_src = wbits;
                default:    ;
            endcase
        end
        if (sel && !wr) begin
            case (reg_idx_e'(idx))
                RG_IRQ_STAT: st_d.rdata = widen(irq_stat);
                RG_RAW:      st_d.rdata = widen(raw_stat);
                RG_EN_SET:   st_d.rdata = widen(st_q.en);
                RG_MODE:     st_d.rdata = widen(st_q.mode);
                RG_LEVEL:    st_d.rdata = widen(st_q.level);
                RG_SRC_SEL:  st_d.rdata = {{(BUS_DW-1){1'b0}}, st_q.src_sel};
                RG_TEST:     st_d.rdata = widen(st_q.test_src);
                RG_FIQ_STAT: st_d.rdata = widen(fiq_stat);
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en       = st_q.en;
    assign mode     = st_q.mode;
    assign level    = st_q.level;
    assign src_sel  = st_q.src_sel;
    assign test_src = st_q.test_src;
    assign rdata    = st_q.rdata;

endmodule

// File: rtl/lvl_intc_cond.sv
module lvl_intc_cond #(
    parameter int unsigned NL = 10,
    parameter logic [NL-1:0] LOW_OK = 10'h014
) (
    input  logic [NL-1:0] pins,
    input  logic [NL-1:0] test_src,
    input  logic          src_sel,
    input  logic [NL-1:0] level,
    output logic [NL-1:0] cond
);

    logic [NL-1:0] picked;

    assign picked = src_sel ? test_src : pins;

    for (genvar i = 0; i < NL; i++) begin : g_line
        if (LOW_OK[i]) begin : g_pol
            assign cond[i] = picked[i] ^ level[i];
        end else begin : g_fixed
            logic unused_lvl;
            assign unused_lvl = level[i];
            assign cond[i]    = picked[i];
        end
    end

endmodule

// File: rtl/lvl_intc_route.sv
module lvl_intc_route #(
    parameter int unsigned NL = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] cond,
    input  logic [NL-1:0] en,
    input  logic [NL-1:0] mode,
    output logic [NL-1:0] irq_stat,
    output logic [NL-1:0] fiq_stat,
    output logic [NL-1:0] raw_stat,
    output logic          irq_o,
    output logic          fiq_o
);

    typedef struct packed {
        logic [NL-1:0] irq_stat;
        logic [NL-1:0] fiq_stat;
        logic [NL-1:0] raw;
        logic          irq;
        logic          fiq;
    } route_t;

    route_t st_d, st_q;

    always_comb begin
        st_d.raw      = cond;
        st_d.irq_stat = cond & en & ~mode;
        st_d.fiq_stat = cond & en & mode;
        st_d.irq      = |st_d.irq_stat;
        st_d.fiq      = |st_d.fiq_stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_stat = st_q.irq_stat;
    assign fiq_stat = st_q.fiq_stat;
    assign raw_stat = st_q.raw;
    assign irq_o    = st_q.irq;
    assign fiq_o    = st_q.fiq;

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 10,
    parameter logic [NUM_LINES-1:0] LOW_OK_MASK = 10'h014
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] irq_src,
    output logic                 irq_o,
    output logic                 fiq_o
);

    logic [NUM_LINES-1:0] en_w, mode_w, level_w, test_w;
    logic [NUM_LINES-1:0] cond_w, irq_stat_w, fiq_stat_w, raw_w;
    logic                 src_sel_w;

    lvl_intc_regs #(.NL(NUM_LINES), .LOW_OK(LOW_OK_MASK)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .irq_stat (irq_stat_w),
        .fiq_stat (fiq_stat_w),
        .raw_stat (raw_w),
        .en       (en_w),
        .mode     (mode_w),
        .level    (level_w),
        .src_sel  (src_sel_w),
        .test_src (test_w),
        .rdata    (bus_rdata)
    );

    lvl_intc_cond #(.NL(NUM_LINES), .LOW_OK(LOW_OK_MASK)) u_cond (
        .pins     (irq_src),
        .test_src (test_w),
        .src_sel  (src_sel_w),
        .level    (level_w),
        .cond     (cond_w)
    );

    lvl_intc_route #(.NL(NUM_LINES)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond     (cond_w),
        .en       (en_w),
        .mode     (mode_w),
        .irq_stat (irq_stat_w),
        .fiq_stat (fiq_stat_w),
        .raw_stat (raw_w),
        .irq_o    (irq_o),
        .fiq_o    (fiq_o)
    );

endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk
    import lvl_intc_pkg::*;
#(
    parameter int unsigned NL = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic [BUS_AW-1:0] addr,
    input logic [BUS_DW-1:0] wdata,
    input logic [BUS_DW-1:0] rdata,
    input logic [NL-1:0]     en,
    input logic [NL-1:0]     mode,
    input logic [NL-1:0]     irq_stat,
    input logic [NL-1:0]     fiq_stat,
    input logic              irq_o,
    input logic              fiq_o
);

    logic set_wr, clr_wr;
    assign set_wr = sel && wr && (addr[BUS_AW-1:2] == RG_EN_SET);
    assign clr_wr = sel && wr && (addr[BUS_AW-1:2] == RG_EN_CLR);

    p_en_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((en & $past(wdata[NL-1:0])) == $past(wdata[NL-1:0])));

    p_en_set_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((en & ~$past(wdata[NL-1:0])) == ($past(en) & ~$past(wdata[NL-1:0]))));

    p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((en & $past(wdata[NL-1:0])) == '0));

    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_wr && !clr_wr) |=> $stable(en));

    p_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat & fiq_stat) == '0);

    p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((irq_stat & ~($past(en) & ~$past(mode))) == '0));

    p_fiq_routed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((fiq_stat & ~($past(en) & $past(mode))) == '0));

    p_irq_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (irq_stat != '0));

    p_fiq_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == (fiq_stat != '0));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !wr) |=> $stable(rdata));

endmodule

bind lvl_intc lvl_intc_chk #(.NL(NUM_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_sel),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .en       (en_w),
    .mode     (mode_w),
    .irq_stat (irq_stat_w),
    .fiq_stat (fiq_stat_w),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o)
);

// File: tb/test_lvl_intc.sv
module test_lvl_intc;

    localparam logic [9:0] LOW = 10'h014;
    localparam logic [5:0] A_IRQ = 6'h00, A_RAW = 6'h04, A_SET = 6'h08, A_CLR = 6'h0C,
                           A_MODE = 6'h10, A_LVL = 6'h14, A_SS = 6'h18, A_TEST = 6'h1C,
                           A_FIQ = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [9:0]  src = '0;
    logic        irq_o, fiq_o;

    int n_chk = 0, n_fail = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    lvl_intc i_lvl_intc (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_src(src), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic br(input logic [5:0] a, output logic [31:0] d);
        repeat (2) @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        d = rdata;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        check("R10 irq_o", {31'd0, irq_o}, 32'd0);
        check("R10 fiq_o", {31'd0, fiq_o}, 32'd0);
        br(A_SET, d);  check("R10 en", d, 32'd0);
        br(A_MODE, d); check("R10 mode", d, 32'd0);
        br(A_LVL, d);  check("R10 level", d, 32'd0);
        br(A_SS, d);   check("R10 srcsel", d, 32'd0);
        br(A_TEST, d); check("R10 test", d, 32'd0);

        // R1 / R2 per-line sweep
        for (int i = 0; i < 10; i++) begin
            bw(A_CLR, 32'hFFFF_FFFF);
            bw(A_SET, 32'd1 << i);
            br(A_SET, d); check("R1 single set", d, 32'd1 << i);
            bw(A_SET, 32'd0);
            br(A_SET, d); check("R1 zero write keeps", d, 32'd1 << i);
            bw(A_SET, 32'h3FF);
            bw(A_CLR, 32'd1 << i);
            br(A_SET, d); check("R2 single clear", d, 32'h3FF & ~(32'd1 << i));
            br(A_CLR, d); check("R2 clear reads 0", d, 32'd0);
        end

        // R12 unused bits and unmapped offsets
        bw(A_MODE, 32'hFFFF_FFFF);
        br(A_MODE, d); check("R12 mode width", d, 32'h3FF);
        bw(A_SS, 32'hFFFF_FFFE);
        br(A_SS, d); check("R12 srcsel width", d, 32'd0);
        br(6'h24, d); check("R12 unmapped", d, 32'd0);
        br(6'h3C, d); check("R12 unmapped top", d, 32'd0);
        bw(A_MODE, 32'd0);

        // R6 level only on lines 2 and 4
        bw(A_LVL, 32'hFFFF_FFFF);
        br(A_LVL, d); check("R6 level readback", d, {22'd0, LOW});
        src = 10'h001;
        br(A_RAW, d); check("R6 polarity ignored on other lines", d, {22'd0, 10'h001 ^ LOW});
        bw(A_LVL, 32'd0);

        // R11 output timing
        bw(A_CLR, 32'h3FF);
        bw(A_SET, 32'h001);
        src = 10'h000;
        repeat (3) @(negedge clk);
        check("R11 idle low", {31'd0, irq_o}, 32'd0);
        src = 10'h001;
        #1;
        check("R11 no change before edge", {31'd0, irq_o}, 32'd0);
        @(posedge clk); #1;
        check("R11 change one edge later", {31'd0, irq_o}, 32'd1);

        // R9 level-sensitive, no acknowledge
        br(A_IRQ, d); check("R9 pending", d, 32'h001);
        br(A_IRQ, d); check("R9 read does not clear", d, 32'h001);
        src = 10'h000;
        br(A_IRQ, d); check("R9 clears with input", d, 32'd0);
        check("R9 irq_o drops", {31'd0, irq_o}, 32'd0);

        // randomized sweep over R3 R4 R5 R6 R7 R8
        for (int k = 0; k < 60; k++) begin
            logic [9:0] s, e, m, l, t, c, ei, ef;
            logic ss;
            rng = nxt(rng); s = rng[9:0]; e = rng[19:10]; m = rng[29:20];
            rng = nxt(rng); l = rng[9:0]; t = rng[19:10]; ss = rng[20];
            bw(A_CLR, 32'h3FF);
            bw(A_SET, {22'd0, e});
            bw(A_MODE, {22'd0, m});
            bw(A_LVL, {rng[31:22], 12'd0, l});
            bw(A_SS, {31'd0, ss});
            bw(A_TEST, {rng[31:22], 12'd0, t});
            src = s;
            c  = (ss ? t : s) ^ (l & LOW);
            ei = c & e & ~m;
            ef = c & e & m;
            br(A_RAW, d); check("R8 raw / R7 source / R6 polarity", d, {22'd0, c});
            br(A_IRQ, d); check("R3 irq status", d, {22'd0, ei});
            br(A_FIQ, d); check("R4 fiq status", d, {22'd0, ef});
            check("R5 irq_o", {31'd0, irq_o}, {31'd0, |ei});
            check("R5 fiq_o", {31'd0, fiq_o}, {31'd0, |ef});
            br(A_SET, d); check("R1 en readback", d, {22'd0, e});
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule